// File: doc/BRIEF.md
# Countdown and Seconds Timer with Register Bus

A timer peripheral reached over a simple register bus: a byte offset, a write strobe, write data, and read data that follows the offset combinationally. A configuration register gives the core one of two jobs. In configuration 0 it is a 32-bit down-counter clocked by the system clock. That counter runs either once or repeatedly. Its expiry raises a status bit and, if enabled, sends a one-cycle pulse on a trigger output for other logic. In configuration 1 it counts seconds from an external one-cycle strobe and wraps to zero once it passes a programmable match value.

Interrupt status is kept raw. Software sees it through a mask and a write-one-to-clear register, and the level interrupt is the OR of the masked bits. Load and match values are held as two 16-bit halves. For configurations below 4 a single 32-bit access reaches both halves; from 4 upward it reaches only the low half. Prescale registers and the second mode register are plain storage. Configurations other than 0 and 1 make nothing count.

Top module: `gpt_timer`

## Requirements
- R1: After reset every register reads 0, `irq` is low and `trig_out` is low.
- R2: With configuration 0, a control write that moves bit 0 from 0 to 1 loads the reload value {high half, low half}. Status bit 0 becomes set exactly N clock edges after the write edge, where N is the reload value (0 behaves like 1).
- R3: In configuration 0 with mode A bit 0 clear (periodic), each expiry reloads the counter, so expiries repeat every N cycles and control bit 0 stays 1.
- R4: With mode A bit 0 set (one-shot), the expiry clears control bit 0 and no further expiry follows.
- R5: When control bit 5 is set, every expiry drives `trig_out` high for exactly one cycle, on the same edge that sets status bit 0. When bit 5 is clear, `trig_out` stays low.
- R6: A control write that clears bit 0 halts the countdown and no expiry follows.
- R7: With configuration 1 and control bit 0 set, each `sec_tick` increments the seconds count. A value that would pass the 32-bit match value becomes 0 instead, and reaching 0 sets status bit 3. Offset 0x48 returns the seconds count in configuration 1 and 0 otherwise. With control bit 0 clear, strobes are ignored.
- R8: A write to the mask (0x18) keeps only bits 0x77. `irq` is high exactly when status AND mask is nonzero, and offset 0x20 reads that AND.
- R9: Writing offset 0x24 clears each status bit written as 1, and offset 0x24 reads 0. An expiry on the same edge as a clear leaves its bit set.
- R10: A write to load A (0x28) or match A (0x30) puts data bits 15:0 in the low half. It puts bits 31:16 in the high half only when the configuration is below 4, and reads of those offsets rebuild the word under the same rule. Load B (0x2C) and match B (0x34) write and read the high half from data bits 15:0.
- R11: Offsets not listed (for example 0x10, 0x4C) read 0, and writes to them change no register. Configurations 2 and above never expire. Prescale A/B (0x38/0x3C) hold and return 8 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the countdown decrements once per edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe marking one second |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, takes effect at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, OR of masked status |
| trig_out | output | 1 | One-cycle pulse on countdown expiry when enabled |

## Verification
The assertions check on every cycle that an expiry always lands in status bit 0, that a trigger pulse never appears without that bit, and that a one-shot expiry drops the run bit. They also check that a seconds tick never leaves the count above the match value, that the clear offset reads zero, and that a zero mask keeps the interrupt low. Only the bench scenarios can show the exact expiry period, the spacing of repeated pulses, the wrap sequence of the seconds count, and the way the configuration value changes how the 16-bit halves are reached.

// File: rtl/gpt_pkg.sv
// Package: shared constants for the countdown/seconds timer.
// Holds the register offsets, the status bit positions and the field widths
// shared by the register block, the counter core and the checker.
package gpt_pkg;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFF_CFG    = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_MODE_A = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_MODE_B = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_MASK   = 12'h018;
    localparam logic [ADDR_W-1:0] OFF_RAW    = 12'h01C;
    localparam logic [ADDR_W-1:0] OFF_MSTAT  = 12'h020;
    localparam logic [ADDR_W-1:0] OFF_CLR    = 12'h024;
    localparam logic [ADDR_W-1:0] OFF_LOAD_A = 12'h028;
    localparam logic [ADDR_W-1:0] OFF_LOAD_B = 12'h02C;
    localparam logic [ADDR_W-1:0] OFF_MAT_A  = 12'h030;
    localparam logic [ADDR_W-1:0] OFF_MAT_B  = 12'h034;
    localparam logic [ADDR_W-1:0] OFF_PRE_A  = 12'h038;
    localparam logic [ADDR_W-1:0] OFF_CNT_A  = 12'h048;

    // Status register layout
    localparam int ST_W    = 7;
    localparam int ST_TO   = 0;   // countdown expiry
    localparam int ST_RTC  = 3;   // seconds count wrapped to zero
    localparam logic [ST_W-1:0] MASK_KEEP = 7'h77;

    // Control register layout
    localparam int CTRL_W     = 16;
    localparam int CTRL_RUN   = 0;
    localparam int CTRL_TRIG  = 5;

    // Configuration codes
    localparam int CFG_W = 3;
    localparam logic [CFG_W-1:0] CFG_COUNTDOWN = 3'd0;
    localparam logic [CFG_W-1:0] CFG_SECONDS   = 3'd1;
    localparam logic [CFG_W-1:0] CFG_SPLIT_MIN = 3'd4;
endpackage

// File: rtl/gpt_regs.sv
// Module: gpt_regs
// Register file and read mux of the timer. Decodes bus writes, keeps the
// configuration, modes, control, mask, raw status, split load/match halves
// and prescale storage, and forms the level interrupt.
// Assumes: reads have no side effect; a bus write and a core event on the
// same edge resolve with write priority for control and set priority for status.
module gpt_regs
    import gpt_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int MODE_W = 4,
    parameter int PRE_W  = 8,
    localparam int DATA_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              expire,
    input  logic              rtc_wrap,
    input  logic [DATA_W-1:0] rtc_cnt,
    output logic [CFG_W-1:0]  cfg,
    output logic              run,
    output logic              trig_en,
    output logic              oneshot,
    output logic              start,
    output logic [DATA_W-1:0] reload,
    output logic [DATA_W-1:0] match,
    output logic [ST_W-1:0]   raw,
    output logic [ST_W-1:0]   mask,
    output logic              irq
);
    logic [CFG_W-1:0]  cfg_q;
    logic [MODE_W-1:0] mode_a_q, mode_b_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [ST_W-1:0]   mask_q, raw_q, set_vec;
    logic [HALF_W-1:0] load_lo_q, load_hi_q, mat_lo_q, mat_hi_q;
    logic [PRE_W-1:0]  pre_q [2];
    logic              wide_access;

    // Per-offset write strobes
    logic wr_cfg, wr_mode_a, wr_mode_b, wr_ctrl, wr_mask, wr_clr;
    logic wr_load_a, wr_load_b, wr_mat_a, wr_mat_b;

    // Decode of which register a bus write targets
    always_comb begin
        wr_cfg    = we && (addr == OFF_CFG);
        wr_mode_a = we && (addr == OFF_MODE_A);
        wr_mode_b = we && (addr == OFF_MODE_B);
        wr_ctrl   = we && (addr == OFF_CTRL);
        wr_mask   = we && (addr == OFF_MASK);
        wr_clr    = we && (addr == OFF_CLR);
        wr_load_a = we && (addr == OFF_LOAD_A);
        wr_load_b = we && (addr == OFF_LOAD_B);
        wr_mat_a  = we && (addr == OFF_MAT_A);
        wr_mat_b  = we && (addr == OFF_MAT_B);
    end

    assign wide_access = (cfg_q < CFG_SPLIT_MIN);

    // Configuration and mode storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            mode_a_q <= '0;
            mode_b_q <= '0;
        end else begin
            if (wr_cfg)    cfg_q    <= wdata[CFG_W-1:0];
            if (wr_mode_a) mode_a_q <= wdata[MODE_W-1:0];
            if (wr_mode_b) mode_b_q <= wdata[MODE_W-1:0];
        end
    end

    // Control register: bus write wins, else a one-shot expiry drops the run bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= wdata[CTRL_W-1:0];
        end else if (expire && mode_a_q[0]) begin
            ctrl_q[CTRL_RUN] <= 1'b0;
        end
    end

    // Start pulse on a control write that raises the run bit
    assign start = wr_ctrl && wdata[CTRL_RUN] && !ctrl_q[CTRL_RUN];

    // Core events that raise status bits
    always_comb begin
        set_vec         = '0;
        set_vec[ST_TO]  = expire;
        set_vec[ST_RTC] = rtc_wrap;
    end

    // Mask and raw status, clear by writing ones, set has priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            raw_q  <= '0;
        end else begin
            if (wr_mask) mask_q <= wdata[ST_W-1:0] & MASK_KEEP;
            raw_q <= (raw_q & ~(wr_clr ? wdata[ST_W-1:0] : '0)) | set_vec;
        end
    end

    // Load and match halves; a wide write reaches the high half only below config 4
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_lo_q <= '0;
            load_hi_q <= '0;
            mat_lo_q  <= '0;
            mat_hi_q  <= '0;
        end else begin
            if (wr_load_a) begin
                load_lo_q <= wdata[HALF_W-1:0];
                if (wide_access) load_hi_q <= wdata[DATA_W-1:HALF_W];
            end else if (wr_load_b) begin
                load_hi_q <= wdata[HALF_W-1:0];
            end
            if (wr_mat_a) begin
                mat_lo_q <= wdata[HALF_W-1:0];
                if (wide_access) mat_hi_q <= wdata[DATA_W-1:HALF_W];
            end else if (wr_mat_b) begin
                mat_hi_q <= wdata[HALF_W-1:0];
            end
        end
    end

    // Prescale storage, one register per half-timer
    for (genvar g = 0; g < 2; g++) begin : g_pre
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pre_q[g] <= '0;
            end else if (we && (addr == OFF_PRE_A + ADDR_W'(4 * g))) begin
                pre_q[g] <= wdata[PRE_W-1:0];
            end
        end
    end

    // Read mux, unmapped offsets return zero
    always_comb begin
        unique case (addr)
            OFF_CFG:    rdata = DATA_W'(cfg_q);
            OFF_MODE_A: rdata = DATA_W'(mode_a_q);
            OFF_MODE_B: rdata = DATA_W'(mode_b_q);
            OFF_CTRL:   rdata = DATA_W'(ctrl_q);
            OFF_MASK:   rdata = DATA_W'(mask_q);
            OFF_RAW:    rdata = DATA_W'(raw_q);
            OFF_MSTAT:  rdata = DATA_W'(raw_q & mask_q);
            OFF_LOAD_A: rdata = {wide_access ? load_hi_q : '0, load_lo_q};
            OFF_LOAD_B: rdata = DATA_W'(load_hi_q);
            OFF_MAT_A:  rdata = {wide_access ? mat_hi_q : '0, mat_lo_q};
            OFF_MAT_B:  rdata = DATA_W'(mat_hi_q);
            OFF_PRE_A:  rdata = DATA_W'(pre_q[0]);
            OFF_PRE_A + ADDR_W'(4): rdata = DATA_W'(pre_q[1]);
            OFF_CNT_A:  rdata = (cfg_q == CFG_SECONDS) ? rtc_cnt : '0;
            default:    rdata = '0;
        endcase
    end

    assign cfg     = cfg_q;
    assign run     = ctrl_q[CTRL_RUN];
    assign trig_en = ctrl_q[CTRL_TRIG];
    assign oneshot = mode_a_q[0];
    assign reload  = {load_hi_q, load_lo_q};
    assign match   = {mat_hi_q, mat_lo_q};
    assign raw     = raw_q;
    assign mask    = mask_q;
    assign irq     = |(raw_q & mask_q);
endmodule

// File: rtl/gpt_core.sv
// Module: gpt_core
// Counting engine of the timer: a down-counter for configuration 0 and a
// seconds counter for configuration 1.
// Assumes: start is a one-cycle pulse at the edge that sets the run bit;
// sec_tick is a one-cycle strobe; reload values 0 and 1 both give a period of 1.
module gpt_core
    import gpt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg,
    input  logic              run,
    input  logic              start,
    input  logic              trig_en,
    input  logic [DATA_W-1:0] reload,
    input  logic [DATA_W-1:0] match,
    input  logic              sec_tick,
    output logic              expire,
    output logic              rtc_wrap,
    output logic              rtc_tick,
    output logic [DATA_W-1:0] rtc_cnt,
    output logic              trig
);
    logic [DATA_W-1:0] cnt_q, rtc_q, rtc_inc, rtc_nxt;
    logic              counting, trig_q;

    assign counting = run && (cfg == CFG_COUNTDOWN);
    assign expire   = counting && (cnt_q <= DATA_W'(1));

    // Down-counter: load on start, reload on expiry, else decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= reload;
        end else if (counting) begin
            cnt_q <= expire ? reload : cnt_q - DATA_W'(1);
        end
    end

    // Trigger pulse registered on the expiry edge
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= expire && trig_en;
    end

    // Next seconds value with wrap past the match value
    always_comb begin
        rtc_inc  = rtc_q + DATA_W'(1);
        rtc_nxt  = (rtc_inc > match) ? '0 : rtc_inc;
        rtc_tick = sec_tick && run && (cfg == CFG_SECONDS);
        rtc_wrap = rtc_tick && (rtc_nxt == '0);
    end

    // Seconds counter advances once per qualified strobe
    always_ff @(posedge clk) begin
        if (!rst_n)        rtc_q <= '0;
        else if (rtc_tick) rtc_q <= rtc_nxt;
    end

    assign rtc_cnt = rtc_q;
    assign trig    = trig_q;
endmodule

// File: rtl/gpt_timer.sv
// Module: gpt_timer (top)
// Bus-mapped timer: joins the register file to the counting engine.
// Assumes: single-cycle register accesses, combinational read data.
module gpt_timer
    import gpt_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter int MODE_W = 4,
    parameter int PRE_W  = 8,
    localparam int DATA_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              trig_out
);
    logic [CFG_W-1:0]  cfg;
    logic              run, trig_en, oneshot, start;
    logic              expire, rtc_wrap, rtc_tick;
    logic [DATA_W-1:0] reload, match, rtc_cnt;
    logic [ST_W-1:0]   raw_st, mask_st;

    gpt_regs #(.HALF_W(HALF_W), .MODE_W(MODE_W), .PRE_W(PRE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
        .wdata(bus_wdata), .rdata(bus_rdata), .expire(expire),
        .rtc_wrap(rtc_wrap), .rtc_cnt(rtc_cnt), .cfg(cfg), .run(run),
        .trig_en(trig_en), .oneshot(oneshot), .start(start),
        .reload(reload), .match(match), .raw(raw_st), .mask(mask_st),
        .irq(irq)
    );

    gpt_core #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .run(run), .start(start),
        .trig_en(trig_en), .reload(reload), .match(match),
        .sec_tick(sec_tick), .expire(expire), .rtc_wrap(rtc_wrap),
        .rtc_tick(rtc_tick), .rtc_cnt(rtc_cnt), .trig(trig_out)
    );
endmodule

// File: rtl/gpt_timer_sva.sv
// Module: gpt_timer_sva
// Checker bound to gpt_timer: relates core events, register state and the
// bus-visible outputs cycle by cycle.
module gpt_timer_sva
    import gpt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic              trig_out,
    input logic [ST_W-1:0]   raw_st,
    input logic [ST_W-1:0]   mask_st,
    input logic              run,
    input logic              oneshot,
    input logic              expire,
    input logic              rtc_tick,
    input logic [DATA_W-1:0] rtc_cnt,
    input logic [DATA_W-1:0] match
);
    // R2: an expiry always lands in status bit 0
    a_r2_expire_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> raw_st[ST_TO]);

    // R5: a trigger pulse only appears alongside the expiry status
    a_r5_trig_with_status: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |-> raw_st[ST_TO]);

    // R4: a one-shot expiry drops the run bit unless the bus rewrites control
    a_r4_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && oneshot && !(bus_we && bus_addr == OFF_CTRL)) |=> !run);

    // R7: a seconds tick never leaves the count above the match value
    a_r7_seconds_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_tick |=> (rtc_cnt <= $past(match)));

    // R9: the clear offset always reads zero
    a_r9_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_CLR) |-> (bus_rdata == '0));

    // R8: a zero mask keeps the interrupt low, and masked-off bit 3 never sticks
    a_r8_no_irq_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_st == '0) |-> !irq);
    a_r8_mask_width: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && bus_addr == OFF_MASK) |-> !mask_st[3]);
endmodule

bind gpt_timer gpt_timer_sva #(.DATA_W(DATA_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .irq(irq), .trig_out(trig_out),
    .raw_st(raw_st), .mask_st(mask_st), .run(run), .oneshot(oneshot),
    .expire(expire), .rtc_tick(rtc_tick), .rtc_cnt(rtc_cnt), .match(match)
);

// File: tb/gpt_timer_bench.sv
// Directed bench for gpt_timer: one task per scenario, each checking itself.
module gpt_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, trig_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    gpt_timer u_gpt_timer (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .trig_out(trig_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // One write: drive at a falling edge, returns at the falling edge after the write edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic strobe();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic quiesce();
        wr(12'h00C, 0);
        wr(12'h024, 32'h7F);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(12'h000, v); check("R1 cfg", v, 0);
        rd(12'h00C, v); check("R1 ctrl", v, 0);
        rd(12'h01C, v); check("R1 raw", v, 0);
        rd(12'h028, v); check("R1 loadA", v, 0);
        rd(12'h048, v); check("R1 cntA", v, 0);
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 trig", {31'b0, trig_out}, 0);
    endtask

    task automatic t_split();
        logic [31:0] v;
        wr(12'h000, 0);
        wr(12'h028, 32'hABCD1234);
        rd(12'h028, v); check("R10 wide load", v, 32'hABCD1234);
        rd(12'h02C, v); check("R10 loadB half", v, 32'h0000ABCD);
        wr(12'h000, 4);
        wr(12'h02C, 32'h5555);
        wr(12'h028, 32'h99991111);
        rd(12'h028, v); check("R10 split loadA", v, 32'h00001111);
        rd(12'h02C, v); check("R10 split loadB", v, 32'h00005555);
        wr(12'h000, 0);
        rd(12'h028, v); check("R10 recombined", v, 32'h55551111);
        wr(12'h034, 32'h7777);
        wr(12'h030, 32'h00000002 | (32'h0 << 16));
        rd(12'h030, v); check("R10 matchA wide", v, 32'h00000002);
        wr(12'h034, 32'h7777);
        rd(12'h030, v); check("R10 matchB to high", v, 32'h77770002);
        wr(12'h030, 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(12'h00C, 32'h0020);
        wr(12'h010, 32'hFFFFFFFF);
        rd(12'h010, v); check("R11 unmapped read", v, 0);
        rd(12'h04C, v); check("R11 unmapped 0x4C", v, 0);
        rd(12'h00C, v); check("R11 ctrl untouched", v, 32'h20);
        wr(12'h038, 32'h1A5);
        wr(12'h03C, 32'h5A);
        rd(12'h038, v); check("R11 prescale A", v, 32'hA5);
        rd(12'h03C, v); check("R11 prescale B", v, 32'h5A);
        wr(12'h00C, 0);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        int bad = 0;
        quiesce();
        wr(12'h000, 0); wr(12'h004, 0); wr(12'h028, 5);
        wr(12'h00C, 32'h21);
        for (int k = 1; k <= 25; k++) begin
            @(negedge clk);
            if (trig_out !== (k % 5 == 0)) bad++;
            if (k == 4) begin rd(12'h01C, v); check("R2 not yet expired", v, 0); end
            if (k == 5) begin rd(12'h01C, v); check("R2 expiry at N", v, 1); end
        end
        check("R3 R5 periodic pulses", bad, 0);
        rd(12'h00C, v); check("R3 run stays", v, 32'h21);
        wr(12'h00C, 0);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        int bad = 0;
        quiesce();
        wr(12'h004, 1); wr(12'h028, 3);
        wr(12'h00C, 32'h21);
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (trig_out !== (k == 3)) bad++;
        end
        check("R4 single pulse", bad, 0);
        rd(12'h00C, v); check("R4 run cleared", v, 32'h20);
        rd(12'h01C, v); check("R4 status", v, 1);
        wr(12'h004, 0);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        quiesce();
        wr(12'h028, 8);
        wr(12'h00C, 1);
        wr(12'h00C, 0);
        repeat (15) @(negedge clk);
        rd(12'h01C, v); check("R6 no expiry after stop", v, 0);
    endtask

    task automatic t_setwins();
        logic [31:0] v;
        int bad = 0;
        quiesce();
        wr(12'h028, 0);
        wr(12'h00C, 1);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (trig_out !== 1'b0) bad++;
        end
        check("R5 no trig when disabled", bad, 0);
        wr(12'h024, 1);
        rd(12'h01C, v); check("R9 set wins over clear", v, 1);
        wr(12'h00C, 0);
    endtask

    task automatic t_mask_clear();
        logic [31:0] v;
        wr(12'h018, 32'hFF);
        rd(12'h018, v); check("R8 mask kept bits", v, 32'h77);
        check("R8 irq high", {31'b0, irq}, 1);
        rd(12'h020, v); check("R8 masked status", v, 1);
        wr(12'h018, 32'h08);
        rd(12'h018, v); check("R8 bit3 dropped", v, 0);
        check("R8 irq low", {31'b0, irq}, 0);
        wr(12'h018, 32'h01);
        wr(12'h024, 1);
        rd(12'h01C, v); check("R9 cleared", v, 0);
        check("R9 irq after clear", {31'b0, irq}, 0);
        rd(12'h024, v); check("R9 clear reads 0", v, 0);
        wr(12'h018, 0);
    endtask

    task automatic t_rtc();
        logic [31:0] v;
        quiesce();
        wr(12'h000, 1);
        wr(12'h030, 2);
        wr(12'h00C, 1);
        strobe(); rd(12'h048, v); check("R7 count 1", v, 1);
        strobe(); rd(12'h048, v); check("R7 count 2", v, 2);
        rd(12'h01C, v); check("R7 no wrap yet", v, 0);
        strobe(); rd(12'h048, v); check("R7 wrap to 0", v, 0);
        rd(12'h01C, v); check("R7 wrap status bit3", v, 8);
        strobe(); rd(12'h048, v); check("R7 after wrap", v, 1);
        wr(12'h00C, 0);
        strobe(); rd(12'h048, v); check("R7 ignored when stopped", v, 1);
        wr(12'h000, 0);
        rd(12'h048, v); check("R7 cntA zero in cfg0", v, 0);
    endtask

    task automatic t_other_cfg();
        logic [31:0] v;
        int bad = 0;
        quiesce();
        wr(12'h000, 2);
        wr(12'h028, 3);
        wr(12'h00C, 32'h21);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (trig_out !== 1'b0) bad++;
        end
        check("R11 cfg2 no pulse", bad, 0);
        rd(12'h01C, v); check("R11 cfg2 no status", v, 0);
        wr(12'h00C, 0);
        wr(12'h000, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_split();
        t_unmapped();
        t_periodic();
        t_oneshot();
        t_stop();
        t_setwins();
        t_mask_clear();
        t_rtc();
        t_other_cfg();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule